// File: doc/BRIEF.md
# SMBus Register/Page Controller

This block is the byte-level half of an SMBus slave. A bit-level bus engine in front of it reports each START (first or repeated) and STOP as a one-cycle pulse and delivers each received byte with a valid strobe. When the engine needs a byte to shift out, it takes `tx_data` and pulses `tx_ack` once the byte has been sent. The controller works out what each transaction means. A command byte loads an 8-bit register pointer. The transaction is then one of these: a plain write of one byte, a pointer-only send, a receive of one byte, a counted block write, a block read, or a page erase.

Writes to the memory behind the block are held in a small buffer and issued only at STOP, one write per clock. Before they are issued, the block can check the transaction against a trailing CRC-8 packet error code. A wrong code drops the data and raises an error flag. A block write that announces more bytes than the buffer holds is cut to the buffer depth and raises a truncation flag. On reads the block appends the packet error code after the data. The memory sits on a plain port with a combinational read, a write strobe and a page-erase strobe.

Top module: `smb_reg_ctrl`

## Requirements
- R1: After reset, `pec_err`, `trunc_flag`, `mem_we` and `mem_erase` are 0, `mem_addr` is 0x00 and `tx_data` is 0xFF.
- R2: In a write transaction addressed to the device (address byte = {DEV_ADDR, 0}), the byte after the address is the command. Any command other than 0xFC and 0xFE loads the pointer at once, so a repeated START into a read returns that location. A command with no data byte causes no memory write.
- R3: A write made of address, command, one data byte, the packet error code when `pec_en`=1, and STOP causes exactly one memory write of the data to the address given by the command.
- R4: A read transaction (address byte = {DEV_ADDR, 1}) that does not follow a block command returns the byte at the pointer first. The pointer does not advance, so a second such read returns the same byte.
- R5: The command 0xFE, followed by STOP (and the packet error code when `pec_en`=1), gives exactly one `mem_erase` pulse with `mem_addr` equal to the pointer. It causes no write, and the pointer is unchanged.
- R6: In a block write (command 0xFC), the first byte after the command is the count N and the N data bytes follow. At STOP they are written to consecutive addresses starting at the pointer. The pointer ends one past the last byte written.
- R7: A block read is command 0xFC, then a repeated START, then {DEV_ADDR, 1}. It returns the count RD_CNT (4), then RD_CNT bytes from consecutive addresses starting at the pointer, then the packet error code. The pointer advances by RD_CNT.
- R8: The packet error code is CRC-8 with polynomial x^8+x^2+x+1, initial value 0 and MSB first. It covers every byte since the first START, including all address bytes and the bytes sent by the block. When `pec_en`=1 the final byte of a write is taken as this code. After each read's data, the code is the next byte sent.
- R9: When `pec_en`=1 and the code received on a write is wrong, no write or erase is issued and `pec_err` goes to 1. It stays at 1 until the next START that follows a STOP.
- R10: A block count above BUF_DEPTH (32) writes only BUF_DEPTH bytes and sets `trunc_flag`. The flag is cleared by the next START that follows a STOP.
- R11: A transaction whose address byte does not match DEV_ADDR is ignored. It causes no write and no change to the pointer.
- R12: Data buffered in a write phase that ends in a repeated START is discarded. No memory write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pec_en | input | 1 | 1: the final byte of every write is a packet error code |
| bus_start | input | 1 | One-cycle pulse on START or repeated START |
| bus_stop | input | 1 | One-cycle pulse on STOP |
| rx_valid | input | 1 | A received byte is on `rx_data` |
| rx_data | input | 8 | Received byte |
| tx_ack | input | 1 | The bus engine has sent `tx_data` |
| tx_data | output | 8 | Next byte to send |
| mem_addr | output | 8 | Memory address (the pointer) |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_erase | output | 1 | Page erase strobe for the page holding `mem_addr` |
| mem_rdata | input | 8 | Combinational read data at `mem_addr` |
| pec_err | output | 1 | Packet error code mismatch on the last write |
| trunc_flag | output | 1 | The last block write count exceeded the buffer |

## Verification
Single-byte writes and receives are tried at every command value except the two reserved codes, switching the error-code mode every other address. This separates decoding by address from decoding by mode, and shows whether the error-code position is counted correctly. Block writes are tried for every count from 0 to 36 under error-code checking. This covers the empty block, the exact buffer fill and the cases past it, and tells a correct clamp apart from off-by-one counting and a wrong final pointer. A combined block read, a corrupted code, a foreign address and a write abandoned by a repeated START each isolate one path that must leave memory untouched or must return a specific byte.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_IGN,
    PH_WCMD,
    PH_WDATA,
    PH_RD
  } phase_t;

  // CRC-8, polynomial 0x07, one byte, MSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] data);
    logic [7:0] c;
    c = crc ^ data;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/smb_rst_sync.sv
module smb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/smb_pec_crc.sv
module smb_pec_crc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       upd,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  logic [7:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr)      crc_d = 8'h00;
    else if (upd) crc_d = smb_pkg::crc8_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          crc_q <= 8'h00;
    else if (clr || upd) crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/smb_wr_buf.sv
module smb_wr_buf #(
  parameter int DEPTH = 32,
  parameter int IW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] ridx,
  output logic [7:0]    rdata
);
  logic [7:0] slot_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        slot_q <= 8'h00;
      else if (we && widx == IW'(g))     slot_q <= wdata;
    end
    assign slot_w[g] = slot_q;
  end

  assign rdata = slot_w[ridx];
endmodule

// File: rtl/smb_reg_ctrl.sv
module smb_reg_ctrl #(
  parameter logic [6:0] DEV_ADDR  = 7'h34,
  parameter int         BUF_DEPTH = 32,
  parameter int         RD_CNT    = 4,
  parameter logic [7:0] BLK_CMD   = 8'hFC,
  parameter logic [7:0] ERASE_CMD = 8'hFE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pec_en,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       tx_ack,
  output logic [7:0] tx_data,
  output logic [7:0] mem_addr,
  output logic [7:0] mem_wdata,
  output logic       mem_we,
  output logic       mem_erase,
  input  logic [7:0] mem_rdata,
  output logic       pec_err,
  output logic       trunc_flag
);
  import smb_pkg::*;

  localparam int         IW      = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam int         CW      = IW + 1;
  localparam logic [8:0] DEPTH9  = 9'(BUF_DEPTH);
  localparam logic [7:0] RDC8    = 8'(RD_CNT);
  localparam logic [7:0] RDC8P1  = 8'(RD_CNT + 1);

  logic rst_ni;
  smb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_ni));

  phase_t        phase_q, phase_d;
  logic          active_q, active_d;
  logic          blk_q, blk_d, ers_q, ers_d;
  logic [7:0]    ptr_q, ptr_d;
  logic [8:0]    npost_q, npost_d;
  logic [7:0]    bcnt_q, bcnt_d;
  logic [7:0]    rdidx_q, rdidx_d;
  logic          pecerr_q, pecerr_d, trunc_q, trunc_d;
  logic          cm_busy_q, cm_busy_d, cm_inc_q, cm_inc_d;
  logic [CW-1:0] cm_idx_q, cm_idx_d, cm_len_q, cm_len_d;
  logic          ers_go_q, ers_go_d;

  logic          crc_clr, crc_upd;
  logic [7:0]    crc_din, crc_q;
  logic          bw_we;
  logic [IW-1:0] bw_idx;
  logic [7:0]    buf_rd;

  logic [8:0]    ndata9, rcv9, len_a9, len9;
  logic          pec_ok;

  smb_pec_crc u_crc (
    .clk(clk), .rst_n(rst_ni), .clr(crc_clr), .upd(crc_upd), .din(crc_din), .crc(crc_q)
  );

  smb_wr_buf #(.DEPTH(BUF_DEPTH), .IW(IW)) u_buf (
    .clk(clk), .rst_n(rst_ni), .we(bw_we), .widx(bw_idx), .wdata(rx_data),
    .ridx(cm_idx_q[IW-1:0]), .rdata(buf_rd)
  );

  // Commit length worked out at STOP
  always_comb begin
    pec_ok = !pec_en || (crc_q == 8'h00 && npost_q != 9'd0);
    if (!pec_en)              ndata9 = npost_q;
    else if (npost_q != 9'd0) ndata9 = npost_q - 9'd1;
    else                      ndata9 = 9'd0;
    rcv9   = (ndata9 != 9'd0) ? ndata9 - 9'd1 : 9'd0;
    len_a9 = (rcv9 < {1'b0, bcnt_q}) ? rcv9 : {1'b0, bcnt_q};
    len9   = (len_a9 < DEPTH9) ? len_a9 : DEPTH9;
  end

  // Byte to send
  always_comb begin
    tx_data = 8'hFF;
    if (phase_q == PH_RD) begin
      if (blk_q) begin
        if (rdidx_q == 8'd0)         tx_data = RDC8;
        else if (rdidx_q <= RDC8)    tx_data = mem_rdata;
        else if (rdidx_q == RDC8P1)  tx_data = crc_q;
      end else begin
        if (rdidx_q == 8'd0)         tx_data = mem_rdata;
        else if (rdidx_q == 8'd1)    tx_data = crc_q;
      end
    end
  end

  // Next state
  always_comb begin
    phase_d  = phase_q;   active_d = active_q;
    blk_d    = blk_q;     ers_d    = ers_q;
    ptr_d    = ptr_q;     npost_d  = npost_q;
    bcnt_d   = bcnt_q;    rdidx_d  = rdidx_q;
    pecerr_d = pecerr_q;  trunc_d  = trunc_q;
    cm_busy_d = cm_busy_q; cm_inc_d = cm_inc_q;
    cm_idx_d = cm_idx_q;  cm_len_d = cm_len_q;
    ers_go_d = 1'b0;
    crc_clr  = 1'b0;      crc_upd  = 1'b0;
    crc_din  = rx_data;
    bw_we    = 1'b0;      bw_idx   = '0;

    if (cm_busy_q) begin
      cm_idx_d = cm_idx_q + CW'(1);
      if (cm_inc_q) ptr_d = ptr_q + 8'd1;
      if (cm_idx_q + CW'(1) == cm_len_q) cm_busy_d = 1'b0;
    end

    if (bus_start) begin
      active_d = 1'b1;
      phase_d  = PH_ADDR;
      npost_d  = 9'd0;
      rdidx_d  = 8'd0;
      ers_d    = 1'b0;
      if (!active_q) begin
        crc_clr  = 1'b1;
        blk_d    = 1'b0;
        pecerr_d = 1'b0;
        trunc_d  = 1'b0;
      end
    end else if (bus_stop) begin
      active_d = 1'b0;
      phase_d  = PH_IDLE;
      if (phase_q == PH_WDATA) begin
        if (!pec_ok) begin
          pecerr_d = 1'b1;
        end else if (ers_q) begin
          ers_go_d = 1'b1;
        end else if (blk_q) begin
          if (len9 != 9'd0) begin
            cm_busy_d = 1'b1; cm_idx_d = '0; cm_len_d = len9[CW-1:0]; cm_inc_d = 1'b1;
          end
        end else if (ndata9 != 9'd0) begin
          cm_busy_d = 1'b1; cm_idx_d = '0; cm_len_d = CW'(1); cm_inc_d = 1'b0;
        end
      end
    end else if (rx_valid) begin
      case (phase_q)
        PH_ADDR: begin
          crc_upd = 1'b1;
          if (rx_data[7:1] == DEV_ADDR) phase_d = rx_data[0] ? PH_RD : PH_WCMD;
          else                          phase_d = PH_IGN;
        end
        PH_WCMD: begin
          crc_upd = 1'b1;
          blk_d   = (rx_data == BLK_CMD);
          ers_d   = (rx_data == ERASE_CMD);
          if (rx_data != BLK_CMD && rx_data != ERASE_CMD) ptr_d = rx_data;
          phase_d = PH_WDATA;
          npost_d = 9'd0;
        end
        PH_WDATA: begin
          crc_upd = 1'b1;
          if (npost_q != 9'h1FF) npost_d = npost_q + 9'd1;
          if (blk_q) begin
            if (npost_q == 9'd0) begin
              bcnt_d = rx_data;
              if ({1'b0, rx_data} > DEPTH9) trunc_d = 1'b1;
            end else if ((npost_q - 9'd1) < DEPTH9) begin
              bw_we  = 1'b1;
              bw_idx = IW'(npost_q - 9'd1);
            end
          end else if (!ers_q && npost_q == 9'd0) begin
            bw_we = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (tx_ack && phase_q == PH_RD) begin
      crc_upd = 1'b1;
      crc_din = tx_data;
      if (rdidx_q != 8'hFF) rdidx_d = rdidx_q + 8'd1;
      if (blk_q && rdidx_q != 8'd0 && rdidx_q <= RDC8) ptr_d = ptr_q + 8'd1;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE; active_q <= 1'b0;
      blk_q    <= 1'b0;    ers_q    <= 1'b0;
      ptr_q    <= 8'h00;   npost_q  <= 9'd0;
      bcnt_q   <= 8'h00;   rdidx_q  <= 8'h00;
      pecerr_q <= 1'b0;    trunc_q  <= 1'b0;
      cm_busy_q <= 1'b0;   cm_inc_q <= 1'b0;
      cm_idx_q <= '0;      cm_len_q <= '0;
      ers_go_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;  active_q <= active_d;
      blk_q    <= blk_d;    ers_q    <= ers_d;
      ptr_q    <= ptr_d;    npost_q  <= npost_d;
      bcnt_q   <= bcnt_d;   rdidx_q  <= rdidx_d;
      pecerr_q <= pecerr_d; trunc_q  <= trunc_d;
      cm_busy_q <= cm_busy_d; cm_inc_q <= cm_inc_d;
      cm_idx_q <= cm_idx_d; cm_len_q <= cm_len_d;
      ers_go_q <= ers_go_d;
    end
  end

  assign mem_addr   = ptr_q;
  assign mem_wdata  = buf_rd;
  assign mem_we     = cm_busy_q;
  assign mem_erase  = ers_go_q;
  assign pec_err    = pecerr_q;
  assign trunc_flag = trunc_q;

  assert_bad_pec_blocks_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_stop && phase_q == PH_WDATA && pec_en && crc_q != 8'h00)
      |=> (!mem_we && !mem_erase && pec_err));

  assert_commit_bounded_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    cm_busy_q |-> (cm_len_q <= CW'(BUF_DEPTH) && cm_idx_q < cm_len_q));

  assert_erase_single_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_erase |=> !mem_erase);

  assert_rdbyte_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_ack && phase_q == PH_RD && !blk_q) |=> $stable(ptr_q));

  assert_foreign_ignored_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (rx_valid && phase_q == PH_IGN && !cm_busy_q) |=> ($stable(ptr_q) && !mem_we));

endmodule

// File: tb/sim_smb_reg_ctrl.sv
module sim_smb_reg_ctrl;
  localparam logic [6:0] DEV = 7'h34;
  localparam int         BD  = 32;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pec_en, bus_start, bus_stop, rx_valid, tx_ack;
  logic [7:0] rx_data, tx_data, mem_addr, mem_wdata, mem_rdata;
  logic       mem_we, mem_erase, pec_err, trunc_flag;

  int nchk = 0, nerr = 0, nwr = 0, ners = 0;
  logic [7:0] last_ers;
  logic [7:0] bc;
  bit done = 1'b0;
  logic [7:0] mem [256];

  always #5 clk = ~clk;

  smb_reg_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pec_en(pec_en), .bus_start(bus_start), .bus_stop(bus_stop),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_ack(tx_ack), .tx_data(tx_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_erase(mem_erase),
    .mem_rdata(mem_rdata), .pec_err(pec_err), .trunc_flag(trunc_flag)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      nwr <= nwr + 1;
    end
    if (mem_erase) begin
      for (int k = 0; k < 16; k++) mem[{mem_addr[7:4], 4'(k)}] <= 8'hFF;
      ners <= ners + 1;
      last_ers <= mem_addr;
    end
  end

  function automatic logic [7:0] bcrc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[7] ^ d[i];
      r  = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return r;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_start(input bit fresh);
    if (fresh) bc = 8'h00;
    bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
  endtask

  task automatic t_stop;
    bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
    repeat (BD + 4) @(negedge clk);
  endtask

  task automatic t_rx(input logic [7:0] b);
    rx_data = b; rx_valid = 1'b1; bc = bcrc(bc, b);
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic t_tx(output logic [7:0] b);
    b = tx_data; tx_ack = 1'b1; bc = bcrc(bc, b);
    @(negedge clk); tx_ack = 1'b0;
  endtask

  task automatic t_cmd(input logic [7:0] c);
    t_start(1'b1); t_rx({DEV, 1'b0}); t_rx(c);
    if (pec_en) t_rx(bc);
    t_stop();
  endtask

  task automatic t_wbyte(input logic [7:0] c, input logic [7:0] d, input bit bad);
    t_start(1'b1); t_rx({DEV, 1'b0}); t_rx(c); t_rx(d);
    if (pec_en) t_rx(bad ? (bc ^ 8'h01) : bc);
    t_stop();
  endtask

  task automatic t_rbyte(output logic [7:0] d, output logic [7:0] p, output logic [7:0] pexp);
    t_start(1'b1); t_rx({DEV, 1'b1}); t_tx(d);
    pexp = bc; t_tx(p);
    t_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, rd, rd2, p, pe;
    int w0, e0, ex;
    rst_n = 1'b0; pec_en = 1'b0; bus_start = 1'b0; bus_stop = 1'b0;
    rx_valid = 1'b0; rx_data = 8'h00; tx_ack = 1'b0;
    for (int k = 0; k < 256; k++) mem[k] = 8'(k) ^ 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1", "tx_data", tx_data, 8'hFF);
    chk("R1", "pec_err", pec_err, 0);
    chk("R1", "trunc_flag", trunc_flag, 0);
    chk("R1", "mem_we", mem_we, 0);
    chk("R1", "mem_erase", mem_erase, 0);
    chk("R1", "mem_addr", mem_addr, 0);

    // R2 pointer-only send
    w0 = nwr;
    t_cmd(8'h55);
    chk("R2", "no write on send", nwr - w0, 0);
    t_rbyte(rd, p, pe);
    chk("R2", "read at loaded pointer", rd, 8'h55 ^ 8'hA5);

    // R3 R4 R8 sweep over command values, PEC mode alternating
    for (int a = 0; a < 256; a++) begin
      if (a == 8'hFC || a == 8'hFE) continue;
      pec_en = a[1];
      d  = 8'(a * 7 + 3);
      w0 = nwr;
      t_wbyte(8'(a), d, 1'b0);
      chk("R3", "write count", nwr - w0, 1);
      chk("R3", "stored byte", mem[a], d);
      t_rbyte(rd, p, pe);
      chk("R4", "receive byte", rd, d);
      chk("R8", "read PEC", p, pe);
      t_rbyte(rd2, p, pe);
      chk("R4", "pointer held", rd2, d);
    end

    // R6 R10 block write sweep
    pec_en = 1'b1;
    for (int n = 0; n <= 36; n++) begin
      for (int k = 0; k < 48; k++) mem[8'h40 + k] = 8'h00;
      t_cmd(8'h40);
      w0 = nwr;
      t_start(1'b1); t_rx({DEV, 1'b0}); t_rx(8'hFC); t_rx(8'(n));
      for (int i = 0; i < n; i++) t_rx(8'(n + i + 1));
      t_rx(bc);
      t_stop();
      ex = (n > BD) ? BD : n;
      chk("R6", "block write count", nwr - w0, ex);
      for (int i = 0; i < ex; i++) chk("R6", "block byte", mem[8'h40 + i], 8'(n + i + 1));
      chk("R6", "beyond block untouched", mem[8'h40 + ex], 0);
      chk("R10", "trunc_flag", trunc_flag, (n > BD) ? 1 : 0);
      t_rbyte(rd, p, pe);
      chk("R6", "pointer after block", rd, 0);
    end

    // R7 block read
    pec_en = 1'b0;
    for (int k = 0; k < 8; k++) mem[8'h60 + k] = 8'(8'h90 + k);
    t_cmd(8'h60);
    t_start(1'b1); t_rx({DEV, 1'b0}); t_rx(8'hFC);
    t_start(1'b0); t_rx({DEV, 1'b1});
    t_tx(rd);
    chk("R7", "block count", rd, 4);
    for (int i = 0; i < 4; i++) begin
      t_tx(rd);
      chk("R7", "block read byte", rd, 8'h90 + i);
    end
    pe = bc; t_tx(p);
    chk("R8", "block read PEC", p, pe);
    t_stop();
    t_rbyte(rd, p, pe);
    chk("R7", "pointer after block read", rd, 8'h94);

    // R5 erase
    pec_en = 1'b1;
    for (int k = 0; k < 16; k++) mem[8'h80 + k] = 8'h11;
    t_cmd(8'h83);
    e0 = ners; w0 = nwr;
    t_cmd(8'hFE);
    chk("R5", "erase count", ners - e0, 1);
    chk("R5", "erase address", last_ers, 8'h83);
    chk("R5", "no write on erase", nwr - w0, 0);
    chk("R5", "page erased", mem[8'h8A], 8'hFF);
    t_rbyte(rd, p, pe);
    chk("R5", "pointer held", rd, 8'hFF);

    // R9 erase with bad PEC
    e0 = ners;
    t_start(1'b1); t_rx({DEV, 1'b0}); t_rx(8'hFE); t_rx(bc ^ 8'h01);
    t_stop();
    chk("R9", "no erase on bad PEC", ners - e0, 0);
    chk("R9", "pec_err after erase", pec_err, 1);

    // R9 write with bad PEC
    mem[8'h10] = 8'h33;
    w0 = nwr;
    t_wbyte(8'h10, 8'hAA, 1'b1);
    chk("R9", "no write on bad PEC", nwr - w0, 0);
    chk("R9", "pec_err set", pec_err, 1);
    chk("R9", "memory kept", mem[8'h10], 8'h33);
    t_start(1'b1);
    chk("R9", "pec_err cleared by START", pec_err, 0);
    t_rx({DEV, 1'b1}); t_tx(rd);
    chk("R2", "pointer from bad-PEC command", rd, 8'h33);
    t_tx(p);
    t_stop();

    // R11 foreign address
    pec_en = 1'b0;
    mem[8'h20] = 8'h44;
    t_cmd(8'h20);
    w0 = nwr;
    t_start(1'b1); t_rx({DEV ^ 7'h01, 1'b0}); t_rx(8'h22); t_rx(8'h99);
    t_stop();
    chk("R11", "no write", nwr - w0, 0);
    t_rbyte(rd, p, pe);
    chk("R11", "pointer unchanged", rd, 8'h44);

    // R12 repeated START drops data
    mem[8'h30] = 8'h55;
    w0 = nwr;
    t_start(1'b1); t_rx({DEV, 1'b0}); t_rx(8'h30); t_rx(8'h77);
    t_start(1'b0); t_rx({DEV, 1'b1}); t_tx(rd);
    t_stop();
    chk("R12", "no write", nwr - w0, 0);
    chk("R12", "memory kept", mem[8'h30], 8'h55);
    chk("R2", "pointer loaded before Sr", rd, 8'h55);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule